// File: doc/BRIEF.md
# Handshaked Parallel Port Controller

This block connects a processor to an external device over a 16-bit parallel path with one output register and one input register. Each register can be handled as a single 16-bit word or as two independent bytes. Each of the three parts on each side (low byte, high byte, whole word) has its own ready/acknowledge handshake lines, its own status flag and its own interrupt mask bit. All of these parts share one interrupt request line.

The processor reaches the block through four byte-wide locations selected by `cpu_addr`. A write or read takes effect on the trailing edge of its strobe, which is the first clock in which the strobe is seen low after having been high. The address, word flag and data are held in registers while the strobe is high. Handshake inputs from the device pass through a synchronizer chain before any state machine uses them. A status byte holds the six part flags and two output-enable bits. The output-enable bits control the drivers for data bits 0-11 and for bits 12-15.

Each output part runs a state machine with three states. OUT_IDLE moves to OUT_READY on an accepted write. OUT_READY moves to OUT_ACKED when the synchronized acknowledge is high. OUT_ACKED returns to OUT_IDLE when that acknowledge goes low. The part's "ready for more" flag is high exactly in OUT_IDLE. Each input part runs a state machine with four states. IN_IDLE moves to IN_FULL when the synchronized ready is high, and the data lanes are captured on that move. IN_FULL moves to IN_ACK on a read of that part. IN_ACK counts out the minimum acknowledge length and then moves to IN_DRAIN. IN_DRAIN returns to IN_IDLE once the synchronized ready is low.

Top module: `hsk_parport`

## Requirements
- R1: After reset, `pin_ordy`, `pin_iack`, `pin_dout_oe` and `irq` are 0. The status byte reads 0x0E and the mask byte reads 0xFF.
- R2: Location 0 is the high data byte and location 1 is the low data byte. Location 2 is the status byte and location 3 is the mask byte. A byte access uses lane [7:0] of `cpu_wdata`/`cpu_rdata`. A word access (`cpu_word`=1) is valid only at location 0 and uses all 16 bits, with the high byte on [15:8]. At other locations the word flag is ignored. Reads of locations 0 and 1 return the captured input data.
- R3: A write takes effect on the trailing edge of `cpu_wr`. A low-byte write drives `pin_dout[7:0]`, a high-byte write drives `pin_dout[15:8]`, and a word write drives all 16 bits. The matching `pin_ordy` bit rises (bit 0 low byte, bit 1 high byte, bit 2 word) and the part's output flag clears.
- R4: An output-ready bit stays high until the synchronized matching `pin_oack` bit is high, and then falls. The output flag is set only after that acknowledge returns low. The output flags are status bit 1 (low byte), bit 2 (high byte) and bit 3 (word).
- R5: A data write to an output part that is not in OUT_IDLE is ignored: the data lanes and the handshake are unchanged.
- R6: When a synchronized `pin_irdy` bit is high in IN_IDLE, the matching lanes of `pin_din` are captured and the input flag is set. The input flags are status bit 4 (low byte), bit 5 (high byte) and bit 6 (word).
- R7: The trailing edge of a read of a full input part raises the matching `pin_iack` bit and clears its flag. The acknowledge stays high for at least ACK_LEN cycles and until the synchronized ready is low.
- R8: `irq` is high when any part flag is 1 and its mask bit (same position as its status bit) is 0. Mask bits 0 and 7 have no source and never raise `irq`.
- R9: Status bit 0 enables `pin_dout_oe[11:0]` and status bit 7 enables `pin_dout_oe[15:12]`. Both reset to 0. A write to the status byte changes only these two bits.
- R10: The three parts on each side are independent. A byte handshake and another part's handshake can be in progress at the same time.
- R11: A read of an input part that is not in IN_FULL produces no acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 2 | Register location |
| cpu_word | input | 1 | 16-bit access at location 0 |
| cpu_wr | input | 1 | Write strobe, acts on its trailing edge |
| cpu_rd | input | 1 | Read strobe, acts on its trailing edge |
| cpu_wdata | input | 16 | Write data |
| cpu_rdata | output | 16 | Read data for the addressed location |
| irq | output | 1 | Interrupt request |
| pin_dout | output | 16 | Output data to the device |
| pin_dout_oe | output | 16 | Per-bit driver enable |
| pin_ordy | output | 3 | Output ready: low, high, word |
| pin_oack | input | 3 | Output acknowledge from the device |
| pin_din | input | 16 | Input data from the device |
| pin_irdy | input | 3 | Input ready from the device |
| pin_iack | output | 3 | Input acknowledge to the device |

## Verification
The bench writes to a byte part whose handshake is still open. A design that latched the write anyway would corrupt data the device had not yet taken. It reads an input part that is empty. A design that did not gate the read would send a false acknowledge. It drops input-ready immediately after a read to measure the minimum acknowledge length, and holds input-ready high to confirm the acknowledge waits for it to fall. It also tries to set the read-only flags through the status byte, and it unmasks bit 0, which has no source. A design that got these wrong would show corrupted flags or a spurious interrupt.

// File: rtl/pp_pkg.sv
package pp_pkg;
    localparam int NPART   = 3;
    localparam int PART_LO = 0;
    localparam int PART_HI = 1;
    localparam int PART_WD = 2;

    localparam logic [1:0] OFS_HI   = 2'd0;
    localparam logic [1:0] OFS_LO   = 2'd1;
    localparam logic [1:0] OFS_STAT = 2'd2;
    localparam logic [1:0] OFS_MASK = 2'd3;

    typedef enum logic [1:0] {OUT_IDLE, OUT_READY, OUT_ACKED} out_st_e;
    typedef enum logic [1:0] {IN_IDLE, IN_FULL, IN_ACK, IN_DRAIN} in_st_e;
endpackage

// File: rtl/pp_sync.sv
module pp_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= '0;
        end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/pp_out_fsm.sv
module pp_out_fsm
    import pp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic ack_s,
    output logic ready,
    output logic idle
);
    out_st_e st, nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= OUT_IDLE;
        else        st <= nxt;
    end

    always_comb begin
        nxt = st;
        unique case (st)
            OUT_IDLE:  if (start)  nxt = OUT_READY;
            OUT_READY: if (ack_s)  nxt = OUT_ACKED;
            OUT_ACKED: if (!ack_s) nxt = OUT_IDLE;
            default:               nxt = OUT_IDLE;
        endcase
    end

    always_comb begin
        ready = (st == OUT_READY);
        idle  = (st == OUT_IDLE);
    end
endmodule

// File: rtl/pp_in_fsm.sv
module pp_in_fsm
    import pp_pkg::*;
#(
    parameter int ACK_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rdy_s,
    input  logic take,
    output logic full,
    output logic ack,
    output logic capture
);
    localparam int CW = $clog2(ACK_LEN + 1);

    in_st_e        st, nxt;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= IN_IDLE;
            cnt <= '0;
        end else begin
            st <= nxt;
            if (st == IN_FULL && take) cnt <= CW'(ACK_LEN - 1);
            else if (st == IN_ACK && cnt != '0) cnt <= cnt - 1'b1;
        end
    end

    always_comb begin
        nxt = st;
        unique case (st)
            IN_IDLE:  if (rdy_s)      nxt = IN_FULL;
            IN_FULL:  if (take)       nxt = IN_ACK;
            IN_ACK:   if (cnt == '0)  nxt = IN_DRAIN;
            IN_DRAIN: if (!rdy_s)     nxt = IN_IDLE;
            default:                  nxt = IN_IDLE;
        endcase
    end

    always_comb begin
        full    = (st == IN_FULL);
        ack     = (st == IN_ACK) || (st == IN_DRAIN);
        capture = (st == IN_IDLE) && rdy_s;
    end
endmodule

// File: rtl/hsk_parport.sv
module hsk_parport
    import pp_pkg::*;
#(
    parameter int ACK_LEN     = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  cpu_addr,
    input  logic        cpu_word,
    input  logic        cpu_wr,
    input  logic        cpu_rd,
    input  logic [15:0] cpu_wdata,
    output logic [15:0] cpu_rdata,
    output logic        irq,
    output logic [15:0] pin_dout,
    output logic [15:0] pin_dout_oe,
    output logic [2:0]  pin_ordy,
    input  logic [2:0]  pin_oack,
    input  logic [15:0] pin_din,
    input  logic [2:0]  pin_irdy,
    output logic [2:0]  pin_iack
);
    localparam int DW      = 16;
    localparam int BW      = DW / 2;
    localparam int LO_SPAN = 12;

    // strobe capture
    logic          wr_q, rd_q;
    logic [1:0]    acc_addr;
    logic          acc_word;
    logic [DW-1:0] acc_data;
    logic          wr_commit, rd_commit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q     <= 1'b0;
            rd_q     <= 1'b0;
            acc_addr <= '0;
            acc_word <= 1'b0;
            acc_data <= '0;
        end else begin
            wr_q <= cpu_wr;
            rd_q <= cpu_rd;
            if (cpu_wr || cpu_rd) begin
                acc_addr <= cpu_addr;
                acc_word <= cpu_word;
                acc_data <= cpu_wdata;
            end
        end
    end

    assign wr_commit = wr_q && !cpu_wr;
    assign rd_commit = rd_q && !cpu_rd;

    // part decode
    logic [NPART-1:0] out_start, in_take;
    always_comb begin
        out_start[PART_WD] = wr_commit && acc_word  && acc_addr == OFS_HI;
        out_start[PART_HI] = wr_commit && !acc_word && acc_addr == OFS_HI;
        out_start[PART_LO] = wr_commit && acc_addr == OFS_LO;
        in_take[PART_WD]   = rd_commit && acc_word  && acc_addr == OFS_HI;
        in_take[PART_HI]   = rd_commit && !acc_word && acc_addr == OFS_HI;
        in_take[PART_LO]   = rd_commit && acc_addr == OFS_LO;
    end

    // synchronizers
    logic [NPART-1:0] oack_s, irdy_s;
    pp_sync #(.W(NPART), .STAGES(SYNC_STAGES)) u_sync_oack (
        .clk(clk), .rst_n(rst_n), .d(pin_oack), .q(oack_s));
    pp_sync #(.W(NPART), .STAGES(SYNC_STAGES)) u_sync_irdy (
        .clk(clk), .rst_n(rst_n), .d(pin_irdy), .q(irdy_s));

    // per-part machines
    logic [NPART-1:0] out_idle, in_full, in_cap;
    for (genvar p = 0; p < NPART; p++) begin : g_part
        pp_out_fsm u_out (
            .clk(clk), .rst_n(rst_n), .start(out_start[p]), .ack_s(oack_s[p]),
            .ready(pin_ordy[p]), .idle(out_idle[p]));
        pp_in_fsm #(.ACK_LEN(ACK_LEN)) u_in (
            .clk(clk), .rst_n(rst_n), .rdy_s(irdy_s[p]), .take(in_take[p]),
            .full(in_full[p]), .ack(pin_iack[p]), .capture(in_cap[p]));
    end

    // data, enables, mask
    logic [DW-1:0] outbuf, inbuf;
    logic          oe_lo, oe_hi;
    logic [7:0]    mask_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            outbuf <= '0;
            inbuf  <= '0;
            oe_lo  <= 1'b0;
            oe_hi  <= 1'b0;
            mask_q <= 8'hFF;
        end else begin
            if (out_start[PART_WD] && out_idle[PART_WD]) outbuf <= acc_data;
            if (out_start[PART_HI] && out_idle[PART_HI]) outbuf[DW-1:BW] <= acc_data[BW-1:0];
            if (out_start[PART_LO] && out_idle[PART_LO]) outbuf[BW-1:0]  <= acc_data[BW-1:0];
            if (in_cap[PART_WD]) inbuf <= pin_din;
            if (in_cap[PART_HI]) inbuf[DW-1:BW] <= pin_din[DW-1:BW];
            if (in_cap[PART_LO]) inbuf[BW-1:0]  <= pin_din[BW-1:0];
            if (wr_commit && acc_addr == OFS_STAT) begin
                oe_lo <= acc_data[0];
                oe_hi <= acc_data[7];
            end
            if (wr_commit && acc_addr == OFS_MASK) mask_q <= acc_data[7:0];
        end
    end

    logic [7:0] status;
    assign status = {oe_hi, in_full, out_idle, oe_lo};

    always_comb begin
        cpu_rdata = '0;
        unique case (cpu_addr)
            OFS_HI:   cpu_rdata = cpu_word ? inbuf : {8'h00, inbuf[DW-1:BW]};
            OFS_LO:   cpu_rdata = {8'h00, inbuf[BW-1:0]};
            OFS_STAT: cpu_rdata = {8'h00, status};
            OFS_MASK: cpu_rdata = {8'h00, mask_q};
        endcase
    end

    assign irq         = |(status[6:1] & ~mask_q[6:1]);
    assign pin_dout    = outbuf;
    assign pin_dout_oe = {{(DW-LO_SPAN){oe_hi}}, {LO_SPAN{oe_lo}}};
endmodule

// File: rtl/hsk_parport_chk.sv
module hsk_parport_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] ordy,
    input logic [2:0] oack_s,
    input logic [2:0] iack,
    input logic [2:0] irdy_s,
    input logic [2:0] in_full,
    input logic [2:0] out_start,
    input logic [2:0] in_take
);
    for (genvar p = 0; p < 3; p++) begin : g_chk
        a_r3_ordy_from_write: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(ordy[p]) |-> $past(out_start[p]));
        a_r4_ordy_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(ordy[p]) |-> $past(oack_s[p]));
        a_r6_flag_from_ready: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(in_full[p]) |-> $past(irdy_s[p]));
        a_r7_iack_until_idle: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(iack[p]) |-> !$past(irdy_s[p]));
        a_r11_iack_from_read: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(iack[p]) |-> $past(in_take[p]));
    end
endmodule

bind hsk_parport hsk_parport_chk chk_i (
    .clk(clk), .rst_n(rst_n), .ordy(pin_ordy), .oack_s(oack_s), .iack(pin_iack),
    .irdy_s(irdy_s), .in_full(in_full), .out_start(out_start), .in_take(in_take));

// File: tb/hsk_parport_tb_top.sv
module hsk_parport_tb_top;
    localparam int ACK_LEN = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cpu_addr = '0;
    logic        cpu_word = 1'b0, cpu_wr = 1'b0, cpu_rd = 1'b0;
    logic [15:0] cpu_wdata = '0;
    logic [15:0] cpu_rdata;
    logic        irq;
    logic [15:0] pin_dout, pin_dout_oe;
    logic [2:0]  pin_ordy, pin_iack;
    logic [2:0]  pin_oack = '0, pin_irdy = '0;
    logic [15:0] pin_din = '0;

    int nchk = 0, nfail = 0;
    bit done = 0;

    always #5 clk = ~clk;

    hsk_parport #(.ACK_LEN(ACK_LEN)) dut_i (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_word(cpu_word),
        .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .irq(irq), .pin_dout(pin_dout), .pin_dout_oe(pin_dout_oe), .pin_ordy(pin_ordy),
        .pin_oack(pin_oack), .pin_din(pin_din), .pin_irdy(pin_irdy), .pin_iack(pin_iack));

    // kind (0 low, 1 high, 2 word), data
    localparam logic [17:0] VEC [6] = '{
        {2'd2, 16'hA55A}, {2'd0, 16'h00C3}, {2'd1, 16'h003C},
        {2'd2, 16'h0000}, {2'd1, 16'h00FF}, {2'd0, 16'h0081}};

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cpu_write(input logic [1:0] a, input logic w, input logic [15:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_word = w; cpu_wdata = d; cpu_wr = 1'b1;
        @(negedge clk);
        cpu_wr = 1'b0;
        @(negedge clk);
    endtask

    task automatic cpu_read(input logic [1:0] a, input logic w, output logic [15:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_word = w; cpu_rd = 1'b1;
        @(negedge clk);
        d = cpu_rdata;
        cpu_rd = 1'b0;
        @(negedge clk);
    endtask

    function automatic logic [1:0] kind_addr(input logic [1:0] k);
        return (k == 2'd0) ? 2'd1 : 2'd0;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end

    initial begin
        logic [15:0] rd, exp_dout;
        int n;
        cyc(4);
        rst_n = 1'b1;
        cyc(2);

        // R1 reset state
        chk("R1 ordy", {13'd0, pin_ordy}, 16'h0);
        chk("R1 iack", {13'd0, pin_iack}, 16'h0);
        chk("R1 oe", pin_dout_oe, 16'h0);
        chk("R1 irq", {15'd0, irq}, 16'h0);
        cpu_read(2'd2, 1'b0, rd); chk("R1 status", rd, 16'h000E);
        cpu_read(2'd3, 1'b0, rd); chk("R1 mask", rd, 16'h00FF);

        // R9 output enables
        cpu_write(2'd2, 1'b0, 16'h0001);
        chk("R9 oe low span", pin_dout_oe, 16'h0FFF);
        cpu_write(2'd2, 1'b0, 16'h0080);
        chk("R9 oe high span", pin_dout_oe, 16'hF000);
        cpu_read(2'd2, 1'b0, rd); chk("R9 status oe_hi", rd, 16'h008E);
        cpu_write(2'd2, 1'b0, 16'h007E);
        cpu_read(2'd2, 1'b0, rd); chk("R9 flags not writable", rd, 16'h000E);
        cpu_write(2'd2, 1'b0, 16'h0081);
        chk("R9 both enables", pin_dout_oe, 16'hFFFF);

        // R3/R4 vector walk
        exp_dout = 16'h0;
        for (int i = 0; i < 6; i++) begin
            logic [1:0] k;
            k = VEC[i][17:16];
            cpu_write(kind_addr(k), k == 2'd2, VEC[i][15:0]);
            if (k == 2'd2) exp_dout = VEC[i][15:0];
            else if (k == 2'd1) exp_dout[15:8] = VEC[i][7:0];
            else exp_dout[7:0] = VEC[i][7:0];
            chk("R3 dout", pin_dout, exp_dout);
            chk("R3 ordy", {13'd0, pin_ordy}, 16'(1 << k));
            cpu_read(2'd2, 1'b0, rd);
            chk("R3 out flag clear", {15'd0, rd[1+k]}, 16'h0);
            cyc(6);
            chk("R4 ordy held", {13'd0, pin_ordy}, 16'(1 << k));
            pin_oack[k] = 1'b1;
            cyc(4);
            chk("R4 ordy drop", {13'd0, pin_ordy}, 16'h0);
            cpu_read(2'd2, 1'b0, rd);
            chk("R4 flag waits ack low", {15'd0, rd[1+k]}, 16'h0);
            pin_oack[k] = 1'b0;
            cyc(4);
            cpu_read(2'd2, 1'b0, rd);
            chk("R4 flag set", {15'd0, rd[1+k]}, 16'h1);
        end

        // R5 write to busy part
        cpu_write(2'd1, 1'b0, 16'h0011);
        cpu_write(2'd1, 1'b0, 16'h0022);
        chk("R5 busy write ignored", {8'h0, pin_dout[7:0]}, 16'h0011);
        // R10 independent parts
        cpu_write(2'd0, 1'b0, 16'h0066);
        chk("R10 two parts busy", {13'd0, pin_ordy}, 16'h0003);
        pin_oack[1] = 1'b1; cyc(4);
        chk("R10 high acked only", {13'd0, pin_ordy}, 16'h0001);
        pin_oack[1] = 1'b0; pin_oack[0] = 1'b1; cyc(4);
        pin_oack[0] = 1'b0; cyc(4);
        chk("R10 all idle", {13'd0, pin_ordy}, 16'h0);

        // R6/R7 word input
        pin_din = 16'hBEEF; pin_irdy[2] = 1'b1; cyc(4);
        cpu_read(2'd2, 1'b0, rd); chk("R6 word flag", rd, 16'h00CF);
        cpu_read(2'd0, 1'b1, rd); chk("R6 word data", rd, 16'hBEEF);
        chk("R7 iack word", {13'd0, pin_iack}, 16'h0004);
        cpu_read(2'd2, 1'b0, rd); chk("R7 flag cleared", rd, 16'h008F);
        cyc(ACK_LEN + 6);
        chk("R7 iack waits ready", {13'd0, pin_iack}, 16'h0004);
        pin_irdy[2] = 1'b0; cyc(5);
        chk("R7 iack released", {13'd0, pin_iack}, 16'h0);
        // R2 byte lanes of captured data
        cpu_read(2'd0, 1'b0, rd); chk("R2 high byte read", rd, 16'h00BE);
        cpu_read(2'd1, 1'b0, rd); chk("R2 low byte read", rd, 16'h00EF);
        chk("R11 no iack when empty", {13'd0, pin_iack}, 16'h0);
        cyc(3);
        chk("R11 still no iack", {13'd0, pin_iack}, 16'h0);
        cpu_write(2'd3, 1'b0, 16'h005A);
        cpu_read(2'd3, 1'b0, rd); chk("R2 mask readback", rd, 16'h005A);

        // R7 minimum acknowledge length
        pin_din = 16'h0034; pin_irdy[0] = 1'b1; cyc(4);
        cpu_read(2'd1, 1'b0, rd); chk("R6 low byte data", rd, 16'h0034);
        pin_irdy[0] = 1'b0;
        n = 1;
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            if (pin_iack[0]) n++;
            else break;
        end
        nchk++;
        if (n < ACK_LEN) begin
            nfail++;
            $display("FAIL R7 ack length actual=%0d expected>=%0d", n, ACK_LEN);
        end

        // R8 interrupt
        cpu_write(2'd3, 1'b0, 16'h00FF);
        chk("R8 all masked", {15'd0, irq}, 16'h0);
        cpu_write(2'd3, 1'b0, 16'h00FE);
        chk("R8 bit0 no source", {15'd0, irq}, 16'h0);
        cpu_write(2'd3, 1'b0, 16'h00FD);
        chk("R8 out low unmasked", {15'd0, irq}, 16'h1);
        cpu_write(2'd1, 1'b0, 16'h0077);
        chk("R8 flag cleared irq", {15'd0, irq}, 16'h0);
        pin_oack[0] = 1'b1; cyc(4); pin_oack[0] = 1'b0; cyc(4);
        chk("R8 irq after ack", {15'd0, irq}, 16'h1);
        cpu_write(2'd3, 1'b0, 16'h00EF);
        chk("R8 in low idle", {15'd0, irq}, 16'h0);
        pin_din = 16'h0099; pin_irdy[0] = 1'b1; cyc(4);
        chk("R8 in low pending", {15'd0, irq}, 16'h1);
        cpu_read(2'd1, 1'b0, rd);
        chk("R8 in low read", {15'd0, irq}, 16'h0);
        pin_irdy[0] = 1'b0; cyc(ACK_LEN + 6);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule